// File: doc/BRIEF.md
# Temperature Result Formatter with Threshold Alarm

This block sits between a temperature converter and the readable result register. A converter hands it a raw reading as a 16-bit two's complement word with four fractional bits (one LSB is 1/16 degree C), together with a valid strobe. The block accepts the reading only when it is idle. It then stays busy for a time that depends on the selected resolution, and publishes the reading when that time is up.

At publication it clears the fractional bits that lie below the selected resolution and updates the result word. It also works out the integer part of the published value and compares it with a signed 8-bit upper trigger and a signed 8-bit lower trigger. The alarm flag is updated from that comparison. A one-cycle done pulse marks each publication.

The resolution code and both triggers are sampled together with the reading, so later changes cannot disturb a conversion that is already running. The busy time is `BUSY_MAX` cycles at full resolution and halves for each step down. `BUSY_MAX` is a power of two and at least 8.

Top module: `temp_result_fmt`

## Requirements
- R1: After synchronous reset the result word is 16'h0550 (+85 C), and the alarm, done and busy outputs are 0.
- R2: The resolution code selects which fractional bits are kept. Code 2'b11 (12 bits) keeps all bits. Code 2'b10 clears bit 0. Code 2'b01 clears bits 1:0. Code 2'b00 (9 bits) clears bits 2:0. All other bits equal the raw word.
- R3: A reading is accepted on a clock edge where `raw_valid` is 1 and `busy` is 0. `busy` is then 1 for exactly `BUSY_MAX >> (3 - code)` cycles.
- R4: `conv_done` is 1 for exactly one cycle, in the first cycle after `busy` falls. The new result word and alarm appear in that same cycle.
- R5: `raw_valid` is ignored while `busy` is 1. The pending conversion keeps its reading and its timing.
- R6: The resolution code and both triggers are taken at acceptance. Changes to them while busy have no effect on the pending result.
- R7: The integer part is the published word shifted arithmetically right by four (rounded toward minus infinity). The alarm is 1 when the integer part is greater than the upper trigger or less than the lower trigger, both compared as signed 8-bit values. Equality does not raise the alarm.
- R8: The alarm changes only in a cycle where `conv_done` is 1, and it is re-evaluated at every conversion.
- R9: A reading presented in the cycle where `conv_done` is 1 is accepted, so back-to-back conversions lose no cycle.
- R10: The result word holds its value in every cycle where `conv_done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_valid | input | 1 | Raw reading is present |
| raw_temp | input | 16 | Raw reading, two's complement, 4 fractional bits |
| res_code | input | 2 | Resolution code, 00 = 9 bits to 11 = 12 bits |
| trig_hi | input | 8 | Signed upper alarm trigger in whole degrees |
| trig_lo | input | 8 | Signed lower alarm trigger in whole degrees |
| temp_word | output | 16 | Published temperature word |
| alarm | output | 1 | Out-of-range flag from the last conversion |
| conv_done | output | 1 | One-cycle publication pulse |
| busy | output | 1 | Conversion in progress |

## Verification
Two functions can fall in the same cycle: the publication of one conversion, with the done pulse and the alarm update, and the acceptance of the next reading. The bench provokes this by holding `raw_valid` high through whole runs of conversions, and also by random strobes. In the cycle after every done pulse that carried a strobe, it checks directly that `busy` has risen. The cycle-level model then confirms that the new conversion keeps its own reading, code and triggers, while the previous word and alarm stay unchanged until the next pulse.

// File: rtl/temp_fmt_pkg.sv
package temp_fmt_pkg;

    localparam int TW     = 16;
    localparam int FRAC   = 4;
    localparam int TRIG_W = 8;
    localparam int INT_W  = TW - FRAC;

    typedef enum logic [1:0] {
        RES_9  = 2'b00,
        RES_10 = 2'b01,
        RES_11 = 2'b10,
        RES_12 = 2'b11
    } res_e;

    typedef logic [TW-1:0]            tword_t;
    typedef logic signed [TRIG_W-1:0] trig_t;
    typedef logic signed [INT_W-1:0]  tint_t;

    typedef struct packed {
        tword_t raw;
        res_e   res;
        trig_t  hi;
        trig_t  lo;
    } job_t;

    // Mask of fractional bits that must read as zero for a given code
    function automatic tword_t dropped_bits(res_e r);
        tword_t m;
        m = '0;
        for (int i = 0; i < FRAC - 1; i++) begin
            if (int'(r) < (FRAC - 1) - i) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Whole-degree part; sign-extended word makes the top bits the integer
    function automatic tint_t whole_part(tword_t w);
        return tint_t'(w[TW-1:FRAC]);
    endfunction

    function automatic tint_t widen_trig(trig_t t);
        return tint_t'(t);
    endfunction

endpackage

// File: rtl/conv_timer.sv
module conv_timer
    import temp_fmt_pkg::*;
#(
    parameter int BUSY_MAX = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  res_e res,
    output logic busy,
    output logic expire
);
    localparam int CW = (BUSY_MAX > 2) ? $clog2(BUSY_MAX) : 1;

    logic [CW-1:0] len_m1 [4];
    logic [CW-1:0] cnt;
    res_e          res_q;
    logic          busy_q;

    for (genvar g = 0; g < 4; g++) begin : g_len
        localparam int L = BUSY_MAX >> (3 - g);
        assign len_m1[g] = CW'(L - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt    <= '0;
            res_q  <= RES_12;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt    <= len_m1[res];
            res_q  <= res;
        end else if (busy_q) begin
            if (cnt == '0) busy_q <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign busy   = busy_q;
    assign expire = busy_q && (cnt == '0);

    // R3: the countdown never exceeds the window picked at start
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt <= len_m1[res_q]));

    // R3: busy cannot drop while cycles remain
    p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt != '0) |=> busy_q);

    // R5: a start is never taken while busy
    p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !start);

endmodule

// File: rtl/res_masker.sv
module res_masker
    import temp_fmt_pkg::*;
(
    input  tword_t raw_i,
    input  res_e   res_i,
    output tword_t word_o
);
    for (genvar i = 0; i < FRAC - 1; i++) begin : g_frac
        localparam logic [1:0] KEEP_AT = 2'((FRAC - 1) - i);
        assign word_o[i] = (2'(res_i) >= KEEP_AT) ? raw_i[i] : 1'b0;
    end
    assign word_o[TW-1:FRAC-1] = raw_i[TW-1:FRAC-1];

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import temp_fmt_pkg::*;
(
    input  tword_t word_i,
    input  trig_t  hi_i,
    input  trig_t  lo_i,
    output logic   hit_o
);
    tint_t whole;
    logic  above;
    logic  below;

    always_comb begin
        whole = whole_part(word_i);
        above = whole > widen_trig(hi_i);
        below = whole < widen_trig(lo_i);
        hit_o = above | below;
    end

endmodule

// File: rtl/temp_result_fmt.sv
module temp_result_fmt
    import temp_fmt_pkg::*;
#(
    parameter int BUSY_MAX = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        raw_valid,
    input  logic [15:0] raw_temp,
    input  logic [1:0]  res_code,
    input  logic [7:0]  trig_hi,
    input  logic [7:0]  trig_lo,
    output logic [15:0] temp_word,
    output logic        alarm,
    output logic        conv_done,
    output logic        busy
);
    localparam tword_t POR_WORD = 16'h0550;

    job_t   job_q;
    tword_t word_q;
    tword_t masked;
    logic   alarm_q;
    logic   done_q;
    logic   hit;
    logic   start;
    logic   expire;
    logic   busy_w;

    assign start = raw_valid && !busy_w;

    conv_timer #(.BUSY_MAX(BUSY_MAX)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .res    (res_e'(res_code)),
        .busy   (busy_w),
        .expire (expire)
    );

    res_masker u_mask (
        .raw_i  (job_q.raw),
        .res_i  (job_q.res),
        .word_o (masked)
    );

    alarm_cmp u_cmp (
        .word_i (masked),
        .hi_i   (job_q.hi),
        .lo_i   (job_q.lo),
        .hit_o  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q   <= '{raw: POR_WORD, res: RES_12, hi: '0, lo: '0};
            word_q  <= POR_WORD;
            alarm_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= expire;
            if (start) begin
                job_q <= '{raw: raw_temp, res: res_e'(res_code),
                           hi: trig_t'(trig_hi), lo: trig_t'(trig_lo)};
            end
            if (expire) begin
                word_q  <= masked;
                alarm_q <= hit;
            end
        end
    end

    assign temp_word = word_q;
    assign alarm     = alarm_q;
    assign conv_done = done_q;
    assign busy      = busy_w;

    // R4: done lasts a single cycle
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R4: done only follows a busy period
    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy_w || $past(busy_w)));

    // R4: busy falling always yields done
    p_fall_gives_done_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_w) |-> done_q);

    // R10: result word frozen outside done
    p_word_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(word_q));

    // R8: alarm frozen outside done
    p_alarm_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(alarm_q));

    // R2: published word carries no bits below the chosen resolution
    p_mask_r2: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ((word_q & dropped_bits(job_q.res)) == '0));

    // R5 R6: captured job untouched by strobes while busy
    p_ignore_r5: assert property (@(posedge clk) disable iff (rst)
        busy_w |=> $stable(job_q));

endmodule

// File: tb/tb_temp_result_fmt.sv
module tb_temp_result_fmt;

    localparam int BMAX = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        raw_valid = 1'b0;
    logic [15:0] raw_temp = '0;
    logic [1:0]  res_code = 2'b11;
    logic [7:0]  trig_hi = '0;
    logic [7:0]  trig_lo = '0;
    logic [15:0] temp_word;
    logic        alarm;
    logic        conv_done;
    logic        busy;

    always #4 clk = ~clk;

    temp_result_fmt #(.BUSY_MAX(BMAX)) dut (
        .clk(clk), .rst(rst), .raw_valid(raw_valid), .raw_temp(raw_temp),
        .res_code(res_code), .trig_hi(trig_hi), .trig_lo(trig_lo),
        .temp_word(temp_word), .alarm(alarm), .conv_done(conv_done), .busy(busy)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    armed = 0;
    string tag   = "R1";

    // behavioural reference state
    bit          m_busy = 0, m_done = 0, m_alarm = 0;
    int          m_left = 0;
    logic [15:0] m_word = 16'h0550;
    logic [15:0] m_raw;
    int          m_res;
    int          m_hi, m_lo;
    bit          pend_b2b = 0;

    function automatic logic [15:0] ref_mask(logic [15:0] w, int code);
        logic [15:0] r = w;
        for (int b = 0; b < 3 - code; b++) r[b] = 1'b0;
        return r;
    endfunction

    function automatic int ref_floor16(logic [15:0] w);
        int v = int'($signed(w));
        if (v >= 0) return v / 16;
        return -((-v + 15) / 16);
    endfunction

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_busy = 0; m_done = 0; m_alarm = 0; m_left = 0; m_word = 16'h0550;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_left == 1) begin
                    int ip;
                    m_busy  = 0;
                    m_done  = 1;
                    m_word  = ref_mask(m_raw, m_res);
                    ip      = ref_floor16(m_word);
                    m_alarm = (ip > m_hi) || (ip < m_lo);
                end else begin
                    m_left = m_left - 1;
                end
            end else if (raw_valid) begin
                m_busy = 1;
                m_res  = int'(res_code);
                m_left = BMAX >> (3 - m_res);
                m_raw  = raw_temp;
                m_hi   = int'($signed(trig_hi));
                m_lo   = int'($signed(trig_lo));
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            check("temp_word R2 R10", int'(temp_word), int'(m_word));
            check("alarm R7 R8", int'(alarm), int'(m_alarm));
            check("conv_done R4", int'(conv_done), int'(m_done));
            check("busy R3 R5", int'(busy), int'(m_busy));
            if (pend_b2b) check("busy after done with strobe R9", int'(busy), 1);
            pend_b2b = conv_done && raw_valid;
        end
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic step(bit v, logic [15:0] r, logic [1:0] c, int hi, int lo);
        raw_valid = v; raw_temp = r; res_code = c;
        trig_hi = 8'(hi); trig_lo = 8'(lo);
        @(negedge clk);
    endtask

    logic [15:0] samples [8] = '{16'h07D0, 16'hFFF8, 16'hFC90, 16'h0191,
                                 16'hFF5E, 16'h00A2, 16'h0190, 16'h0557};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tag = "R1";
        check("reset word R1", int'(temp_word), 16'h0550);
        check("reset alarm R1", int'(alarm), 0);
        check("reset done R1", int'(conv_done), 0);
        check("reset busy R1", int'(busy), 0);
        armed = 1;

        tag = "R2 R3 R4 R7";
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 8; s++) begin
                step(1, samples[s], 2'(c), 25, -1);
                step(0, 16'h0, 2'(c), 25, -1);
                repeat (BMAX + 1) step(0, 16'h0, 2'(c), 25, -1);
                step(1, samples[s], 2'(c), -56, 0);
                repeat (BMAX + 2) step(0, 16'h0, 2'(c), -56, 0);
            end
        end

        tag = "R5 R6";
        for (int k = 0; k < 4; k++) begin
            step(1, 16'h0328, 2'b11, 40, 10);
            for (int j = 0; j < 6; j++)
                step(1, 16'(16'hFC00 + j), 2'(j), -100, 100);
            repeat (BMAX + 2) step(0, 16'hFFFF, 2'b00, -100, 100);
        end

        tag = "R9";
        for (int j = 0; j < 80; j++)
            step(1, 16'(j * 37), 2'(j % 4), j % 7, -(j % 5));
        step(0, 16'h0, 2'b11, 0, 0);
        repeat (BMAX + 2) step(0, 16'h0, 2'b11, 0, 0);

        tag = "R8 R10";
        for (int j = 0; j < 3000; j++) begin
            logic [31:0] r = $urandom;
            step(($urandom % 5) == 0, {{4{r[11]}}, r[11:0]}, r[13:12],
                 int'($signed(r[23:16])), int'($signed(r[31:24])));
        end
        repeat (BMAX + 2) step(0, 16'h0, 2'b11, 0, 0);

        finish_run();
    end

endmodule